// File: doc/BRIEF.md
# Nested Vectored Interrupt Controller

This block collects 32 interrupt request lines, latches each one as a pending request and picks the most urgent eligible request to hand to a processor. Each source has its own enable bit, pending flag, active flag and 4-bit priority. A numerically smaller priority is more urgent. A global mask input and a base-priority threshold input both gate delivery. Software reaches the enable, pending, active and priority state through a simple word-addressed write/read port. The set and clear registers act only on the bits written as 1.

The processor side is modelled as a handshake. The controller raises a request-valid flag with the number of the winning source. The processor answers with a one-cycle enter pulse when it starts that handler, and with a one-cycle exit pulse when the handler returns. Handlers nest: a pending request preempts the running handler only when its priority is strictly more urgent than the level now in service. Each enter pushes the level it accepts onto a nesting stack of 16 entries, and each exit pops that stack, which restores the level of the interrupted handler.

Top module: `vec_irq_ctrl`

## Requirements
- R1: A write to word 0 sets, and a write to word 1 clears, every enable bit whose data bit is 1. Data bits of 0 leave the enable unchanged. A read of word 0 or word 1 returns the enable vector (bit n = source n).
- R2: A write to word 2 sets, and a write to word 3 clears, every pending flag whose data bit is 1. Data bits of 0 have no effect. A read of word 2 or word 3 returns the pending vector, and a read of word 4 returns the active vector.
- R3: The priority of source n is held in word 8 + n/4, in byte lane n mod 4. Only bits [8*lane+7 : 8*lane+4] are stored. The low four bits of every byte read as zero.
- R4: A source becomes pending on a rising edge of its request line, or whenever its line is high while the source is not active. A pulse stays latched after the line falls.
- R5: The request-valid output is high only for a source that is enabled and pending, while the global mask is 0 and either the threshold is 0 or the source's priority is numerically below the threshold.
- R6: Among eligible sources, the smallest priority value wins. On equal priority, the lowest source number wins.
- R7: An accepted enter pulse clears the delivered source's pending flag and sets its active flag. A rising edge while the source is active sets pending again, giving the pending-and-active state.
- R8: An exit pulse clears the active flag of the innermost handler. That source is left pending if its line is high at exit or if it was pending-and-active. Otherwise it becomes inactive.
- R9: A request preempts a running handler only when its priority is strictly below the level in service. Equal or less urgent requests wait. Each exit restores the level of the interrupted handler, or no level at all when no handler is active.
- R10: When a clear-pending write and a hardware request for the same source fall in the same cycle, the hardware request wins and the source stays pending.
- R11: After reset, all enables, pending flags, active flags and priorities are zero, and request-valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_i | input | 32 | Request line per source |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |
| glob_mask_i | input | 1 | 1 blocks all delivery |
| base_thr_i | input | 4 | Priority threshold; 0 disables the threshold |
| cpu_req_valid_o | output | 1 | A request is offered to the processor |
| cpu_req_num_o | output | 5 | Number of the offered source |
| cpu_enter_i | input | 1 | Processor enters the offered handler (one cycle) |
| cpu_exit_i | input | 1 | Processor leaves the innermost handler (one cycle) |

## Verification
A wrong pending or active flag appears in the cycle after the edge that produced it. It shows on the pending or active read words, and usually also on request-valid, which is derived combinationally from that state. A corrupted nesting stack hides until the following exit pulse. At that point the controller either offers a request that should still wait behind a more urgent handler, or withholds one that should now be offered. The bench therefore follows every exit with a check of the restored delivery decision. An arbitration fault shows at once on the offered source number whenever two eligible sources differ in priority or share a priority.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int PRIO_W        = 4;
  localparam int LANE_W        = 8;
  localparam int REG_EN_SET    = 0;
  localparam int REG_EN_CLR    = 1;
  localparam int REG_PEND_SET  = 2;
  localparam int REG_PEND_CLR  = 3;
  localparam int REG_ACTIVE    = 4;
  localparam int REG_PRIO_BASE = 8;

  // threshold of zero lets every level through
  function automatic logic passes_thr(input logic [PRIO_W-1:0] p,
                                      input logic [PRIO_W-1:0] thr);
    return (thr == '0) || (p < thr);
  endfunction

  // level carries one extra bit: all-ones above PRIO_W means idle
  function automatic logic beats_level(input logic [PRIO_W-1:0] p,
                                       input logic [PRIO_W:0]   lvl);
    return {1'b0, p} < lvl;
  endfunction
endpackage

// File: rtl/vic_regs.sv
module vic_regs
  import vic_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int ADDR_W = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [31:0]               wdata_i,
  input  logic [N_SRC-1:0]          pend_i,
  input  logic [N_SRC-1:0]          act_i,
  output logic [N_SRC-1:0]          en_o,
  output logic [N_SRC*PRIO_W-1:0]   prio_o,
  output logic [N_SRC-1:0]          pend_set_o,
  output logic [N_SRC-1:0]          pend_clr_o,
  output logic [31:0]               rdata_o
);
  logic [N_SRC-1:0] en_set, en_clr;

  always_comb begin
    en_set     = (we_i && addr_i == ADDR_W'(REG_EN_SET))   ? wdata_i[N_SRC-1:0] : '0;
    en_clr     = (we_i && addr_i == ADDR_W'(REG_EN_CLR))   ? wdata_i[N_SRC-1:0] : '0;
    pend_set_o = (we_i && addr_i == ADDR_W'(REG_PEND_SET)) ? wdata_i[N_SRC-1:0] : '0;
    pend_clr_o = (we_i && addr_i == ADDR_W'(REG_PEND_CLR)) ? wdata_i[N_SRC-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_o <= '0;
    else        en_o <= (en_o | en_set) & ~en_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_o <= '0;
    end else if (we_i) begin
      for (int i = 0; i < N_SRC; i++) begin
        if (addr_i == ADDR_W'(REG_PRIO_BASE + i / 4))
          prio_o[i*PRIO_W +: PRIO_W] <= wdata_i[LANE_W*(i%4)+LANE_W-1 -: PRIO_W];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(REG_EN_SET) || addr_i == ADDR_W'(REG_EN_CLR))
      rdata_o[N_SRC-1:0] = en_o;
    else if (addr_i == ADDR_W'(REG_PEND_SET) || addr_i == ADDR_W'(REG_PEND_CLR))
      rdata_o[N_SRC-1:0] = pend_i;
    else if (addr_i == ADDR_W'(REG_ACTIVE))
      rdata_o[N_SRC-1:0] = act_i;
    for (int i = 0; i < N_SRC; i++) begin
      if (addr_i == ADDR_W'(REG_PRIO_BASE + i / 4))
        rdata_o[LANE_W*(i%4)+LANE_W-1 -: PRIO_W] = prio_o[i*PRIO_W +: PRIO_W];
    end
  end
endmodule

// File: rtl/vic_state.sv
module vic_state #(
  parameter int N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_i,
  input  logic [N_SRC-1:0] sw_set_i,
  input  logic [N_SRC-1:0] sw_clr_i,
  input  logic [N_SRC-1:0] enter_vec_i,
  input  logic [N_SRC-1:0] exit_vec_i,
  output logic [N_SRC-1:0] hw_set_o,
  output logic [N_SRC-1:0] pend_o,
  output logic [N_SRC-1:0] act_o
);
  logic [N_SRC-1:0] irq_q, rise;

  always_comb begin
    rise     = irq_i & ~irq_q;
    // level requests are held off for the source being entered
    hw_set_o = rise | (irq_i & ~act_o & ~enter_vec_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= '0;
      pend_o <= '0;
      act_o  <= '0;
    end else begin
      irq_q  <= irq_i;
      pend_o <= ((pend_o | sw_set_i) & ~sw_clr_i & ~enter_vec_i)
                | hw_set_o | (exit_vec_i & irq_i);
      act_o  <= (act_o | enter_vec_i) & ~exit_vec_i;
    end
  end
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter
  import vic_pkg::*;
#(
  parameter int N_SRC = 32,
  parameter int NUM_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]        en_i,
  input  logic [N_SRC-1:0]        pend_i,
  input  logic [N_SRC*PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]       thr_i,
  output logic                    any_o,
  output logic [NUM_W-1:0]        num_o,
  output logic [PRIO_W-1:0]       prio_o
);
  // ascending scan with strict compare keeps the lower number on a tie
  always_comb begin
    any_o  = 1'b0;
    num_o  = '0;
    prio_o = '1;
    for (int i = 0; i < N_SRC; i++) begin
      if (en_i[i] && pend_i[i] && passes_thr(prio_i[i*PRIO_W +: PRIO_W], thr_i) &&
          (!any_o || prio_i[i*PRIO_W +: PRIO_W] < prio_o)) begin
        any_o  = 1'b1;
        num_o  = NUM_W'(i);
        prio_o = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/vic_nest.sv
module vic_nest
  import vic_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int NUM_W = 5,
  parameter int IW    = $clog2(DEPTH),
  parameter int DW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [NUM_W-1:0]  push_num_i,
  input  logic [PRIO_W-1:0] push_prio_i,
  output logic [NUM_W-1:0]  top_num_o,
  output logic [PRIO_W:0]   level_o,
  output logic [DW-1:0]     depth_o,
  output logic              full_o,
  output logic              empty_o
);
  logic [NUM_W-1:0]  num_mem [DEPTH];
  logic [PRIO_W-1:0] lvl_mem [DEPTH];
  logic [IW-1:0]     top_idx;

  always_comb begin
    empty_o   = (depth_o == '0);
    full_o    = (depth_o == DW'(DEPTH));
    top_idx   = IW'(depth_o - 1'b1);
    top_num_o = num_mem[top_idx];
    level_o   = empty_o ? {1'b1, {PRIO_W{1'b0}}} : {1'b0, lvl_mem[top_idx]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      depth_o <= '0;
    else if (push_i) depth_o <= depth_o + 1'b1;
    else if (pop_i)  depth_o <= depth_o - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (push_i) begin
      num_mem[IW'(depth_o)] <= push_num_i;
      lvl_mem[IW'(depth_o)] <= push_prio_i;
    end
  end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vic_pkg::*;
#(
  parameter  int N_SRC      = 32,
  parameter  int NEST_DEPTH = 16,
  parameter  int ADDR_W     = 6,
  localparam int NUM_W      = $clog2(N_SRC),
  localparam int DW         = $clog2(NEST_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  irq_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              glob_mask_i,
  input  logic [PRIO_W-1:0] base_thr_i,
  output logic              cpu_req_valid_o,
  output logic [NUM_W-1:0]  cpu_req_num_o,
  input  logic              cpu_enter_i,
  input  logic              cpu_exit_i
);
  logic [N_SRC-1:0]        en_q, pend_q, act_q, hw_set;
  logic [N_SRC-1:0]        sw_set, sw_clr, enter_vec, exit_vec;
  logic [N_SRC*PRIO_W-1:0] prio_q;
  logic                    win_any, enter_ok, exit_ok, nest_full, nest_empty;
  logic [PRIO_W-1:0]       win_prio;
  logic [NUM_W-1:0]        top_num;
  logic [PRIO_W:0]         cur_level;
  logic [DW-1:0]           depth;

  vic_regs #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .pend_i(pend_q), .act_i(act_q), .en_o(en_q),
    .prio_o(prio_q), .pend_set_o(sw_set), .pend_clr_o(sw_clr),
    .rdata_o(reg_rdata_o)
  );

  vic_state #(.N_SRC(N_SRC)) u_state (
    .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .sw_set_i(sw_set),
    .sw_clr_i(sw_clr), .enter_vec_i(enter_vec), .exit_vec_i(exit_vec),
    .hw_set_o(hw_set), .pend_o(pend_q), .act_o(act_q)
  );

  vic_arbiter #(.N_SRC(N_SRC), .NUM_W(NUM_W)) u_arb (
    .en_i(en_q), .pend_i(pend_q), .prio_i(prio_q), .thr_i(base_thr_i),
    .any_o(win_any), .num_o(cpu_req_num_o), .prio_o(win_prio)
  );

  vic_nest #(.DEPTH(NEST_DEPTH), .NUM_W(NUM_W)) u_nest (
    .clk(clk), .rst_n(rst_n), .push_i(enter_ok), .pop_i(exit_ok),
    .push_num_i(cpu_req_num_o), .push_prio_i(win_prio), .top_num_o(top_num),
    .level_o(cur_level), .depth_o(depth), .full_o(nest_full),
    .empty_o(nest_empty)
  );

  always_comb begin
    cpu_req_valid_o = win_any && !glob_mask_i && !nest_full &&
                      beats_level(win_prio, cur_level);
    exit_ok   = cpu_exit_i && !nest_empty;
    enter_ok  = cpu_enter_i && cpu_req_valid_o && !cpu_exit_i;
    enter_vec = enter_ok ? (N_SRC'(1) << cpu_req_num_o) : '0;
    exit_vec  = exit_ok  ? (N_SRC'(1) << top_num) : '0;
  end
endmodule

// File: rtl/vec_irq_ctrl_chk.sv
module vec_irq_ctrl_chk #(
  parameter int N_SRC  = 32,
  parameter int ADDR_W = 6,
  parameter int DEPTH  = 16,
  parameter int DW     = 5,
  parameter int NUM_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              glob_mask_i,
  input logic              req_valid,
  input logic [NUM_W-1:0]  req_num,
  input logic              enter_ok,
  input logic              exit_ok,
  input logic [N_SRC-1:0]  en_q,
  input logic [N_SRC-1:0]  pend_q,
  input logic [N_SRC-1:0]  act_q,
  input logic [N_SRC-1:0]  hw_set,
  input logic [DW-1:0]     depth,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_rdata
);
  // R3
  prio_low_nibble_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr >= ADDR_W'(8)) |-> ((reg_rdata & 32'h0F0F_0F0F) == 32'h0));

  // R5
  mask_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    glob_mask_i |-> !req_valid);

  // R5
  offered_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (en_q[req_num] && pend_q[req_num]));

  // R7
  enter_activates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enter_ok |=> act_q[$past(req_num)]);

  // R9
  exit_pops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exit_ok |=> ((depth + 1'b1) == $past(depth)));

  // R9
  nest_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(act_q) <= int'(depth)) && (int'(depth) <= DEPTH));

  // R10
  hw_request_latches_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_set) |=> ((pend_q & $past(hw_set)) == $past(hw_set)));
endmodule

bind vec_irq_ctrl vec_irq_ctrl_chk #(
  .N_SRC(N_SRC), .ADDR_W(ADDR_W), .DEPTH(NEST_DEPTH), .DW(DW), .NUM_W(NUM_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .glob_mask_i(glob_mask_i),
  .req_valid(cpu_req_valid_o), .req_num(cpu_req_num_o),
  .enter_ok(enter_ok), .exit_ok(exit_ok), .en_q(en_q), .pend_q(pend_q),
  .act_q(act_q), .hw_set(hw_set), .depth(depth), .reg_addr(reg_addr_i),
  .reg_rdata(reg_rdata_o)
);

// File: tb/vec_irq_ctrl_tb.sv
module vec_irq_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] irq_i;
  logic        reg_we_i;
  logic [5:0]  reg_addr_i;
  logic [31:0] reg_wdata_i;
  logic [31:0] reg_rdata_o;
  logic        glob_mask_i;
  logic [3:0]  base_thr_i;
  logic        cpu_req_valid_o;
  logic [4:0]  cpu_req_num_o;
  logic        cpu_enter_i;
  logic        cpu_exit_i;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .reg_we_i(reg_we_i),
    .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .glob_mask_i(glob_mask_i),
    .base_thr_i(base_thr_i), .cpu_req_valid_o(cpu_req_valid_o),
    .cpu_req_num_o(cpu_req_num_o), .cpu_enter_i(cpu_enter_i),
    .cpu_exit_i(cpu_exit_i)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // {valid, number} packed for one compare; number only counts when valid
  function automatic logic [31:0] offer();
    return cpu_req_valid_o ? {26'd0, 1'b1, cpu_req_num_o} : 32'd0;
  endfunction
  function automatic logic [31:0] want(input int n);
    return {26'd0, 1'b1, 5'(n)};
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; irq_i = '0; reg_we_i = 1'b0; reg_addr_i = '0;
    reg_wdata_i = '0; glob_mask_i = 1'b0; base_thr_i = '0;
    cpu_enter_i = 1'b0; cpu_exit_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic pulse(input int n);
    irq_i[n] = 1'b1;
    @(negedge clk);
    irq_i[n] = 1'b0;
    #1;
  endtask

  task automatic enter_h();
    cpu_enter_i = 1'b1;
    @(negedge clk);
    cpu_enter_i = 1'b0;
    #1;
  endtask

  task automatic exit_h();
    cpu_exit_i = 1'b1;
    @(negedge clk);
    cpu_exit_i = 1'b0;
    #1;
  endtask

  task automatic test_reset();
    logic [31:0] d;
    do_reset();
    chk("R11 valid after reset", {31'd0, cpu_req_valid_o}, 32'd0);
    rd(6'd0, d); chk("R11 enable after reset", d, 32'd0);
    rd(6'd2, d); chk("R11 pending after reset", d, 32'd0);
    rd(6'd4, d); chk("R11 active after reset", d, 32'd0);
    rd(6'd9, d); chk("R11 priority after reset", d, 32'd0);
  endtask

  task automatic test_regs();
    logic [31:0] d;
    do_reset();
    wr(6'd0, 32'h0000_00F0);
    rd(6'd0, d); chk("R1 set enable", d, 32'h0000_00F0);
    wr(6'd0, 32'h0000_0001);
    rd(6'd1, d); chk("R1 zero bits keep enable", d, 32'h0000_00F1);
    wr(6'd1, 32'h0000_0030);
    rd(6'd0, d); chk("R1 clear enable", d, 32'h0000_00C1);
    wr(6'd2, 32'h0000_1000);
    rd(6'd3, d); chk("R2 set pending", d, 32'h0000_1000);
    wr(6'd3, 32'h0000_0000);
    rd(6'd2, d); chk("R2 zero clear has no effect", d, 32'h0000_1000);
    wr(6'd3, 32'h0000_1000);
    rd(6'd2, d); chk("R2 clear pending", d, 32'h0);
    wr(6'd9, 32'hABCD_EF12);
    rd(6'd9, d); chk("R3 upper nibbles only", d, 32'hA0C0_E010);
    rd(6'd8, d); chk("R3 other word untouched", d, 32'h0);
  endtask

  task automatic test_deliver();
    logic [31:0] d;
    do_reset();
    wr(6'd0, 32'hFFFF_FFFF);
    wr(6'd8, 32'h2000_0000);             // source 3 priority 2
    pulse(5);
    rd(6'd2, d); chk("R4 edge pulse latched", d, 32'h0000_0020);
    chk("R5 single request offered", offer(), want(5));
    pulse(3);
    chk("R6 lower value wins over lower number", offer(), want(5));
    wr(6'd8, 32'h0000_0000);             // source 3 priority 0: tie
    #1 chk("R6 tie goes to lower number", offer(), want(3));
    wr(6'd8, 32'h4000_0000);             // source 3 priority 4
    wr(6'd9, 32'h0000_3000);             // source 5 priority 3
    glob_mask_i = 1'b1; #1;
    chk("R5 global mask blocks", offer(), 32'd0);
    glob_mask_i = 1'b0; base_thr_i = 4'd3; #1;
    chk("R5 threshold equal blocks", offer(), 32'd0);
    base_thr_i = 4'd4; #1;
    chk("R5 below threshold passes", offer(), want(5));
    base_thr_i = 4'd0; #1;
    chk("R5 zero threshold passes", offer(), want(5));
    irq_i[9] = 1'b1;
    @(negedge clk);
    wr(6'd3, 32'h0000_0200);
    rd(6'd2, d); chk("R4 level held keeps pending", d & 32'h200, 32'h200);
    irq_i[9] = 1'b0;
    @(negedge clk);
    wr(6'd3, 32'h0000_0200);
    rd(6'd2, d); chk("R4 clears once line low", d & 32'h200, 32'h0);
    reg_we_i = 1'b1; reg_addr_i = 6'd3; reg_wdata_i = 32'h0000_0080;
    irq_i[7] = 1'b1;
    @(negedge clk);
    reg_we_i = 1'b0; irq_i[7] = 1'b0;
    @(negedge clk);
    rd(6'd2, d); chk("R10 edge beats clear write", d & 32'h80, 32'h80);
  endtask

  task automatic test_nesting();
    logic [31:0] d;
    do_reset();
    wr(6'd0, 32'hFFFF_FFFF);
    wr(6'd8, 32'h0040_8080);             // src0=8, src1=8, src2=4
    pulse(1);
    chk("R5 first request", offer(), want(1));
    enter_h();
    rd(6'd4, d); chk("R7 enter sets active", d, 32'h2);
    rd(6'd2, d); chk("R7 enter clears pending", d, 32'h0);
    pulse(0);
    chk("R9 equal priority waits", offer(), 32'd0);
    pulse(2);
    chk("R9 more urgent preempts", offer(), want(2));
    enter_h();
    rd(6'd4, d); chk("R9 nested active", d, 32'h6);
    pulse(2);
    rd(6'd2, d); chk("R7 edge while active re-pends", d & 32'h4, 32'h4);
    chk("R9 same level no re-entry", offer(), 32'd0);
    exit_h();
    rd(6'd4, d); chk("R8 exit clears active", d, 32'h2);
    rd(6'd2, d); chk("R8 pending-and-active stays pending", d & 32'h4, 32'h4);
    chk("R9 level restored after exit", offer(), want(2));
    irq_i[2] = 1'b1;
    @(negedge clk);
    enter_h();
    rd(6'd2, d); chk("R7 level held not re-pending while active", d & 32'h4, 32'h0);
    exit_h();
    rd(6'd2, d); chk("R8 line high at exit re-pends", d & 32'h4, 32'h4);
    irq_i[2] = 1'b0;
    @(negedge clk);
    chk("R8 re-pended request offered", offer(), want(2));
    enter_h();
    exit_h();
    rd(6'd2, d); chk("R8 line low at exit goes inactive", d & 32'h4, 32'h0);
    chk("R9 equal level still waits", offer(), 32'd0);
    exit_h();
    rd(6'd4, d); chk("R8 outer exit clears active", d, 32'h0);
    chk("R9 idle after last exit", offer(), want(0));
  endtask

  initial begin
    test_reset();
    test_regs();
    test_deliver();
    test_nesting();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule